// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block holds a set of event counters that software reaches through a compact word-wide register window. One index register picks which counter the configuration, preload and snapshot operations act on, so the window stays the same size however many counters are built. Each counter watches one line of a vector of hardware condition inputs. The line is picked by an event code in its configuration. Two qualifier bits can restrict counting to user or kernel privilege.

A single run bit in the control register starts and stops every counter at once. To stop one counter, software writes event code 0, which never matches. Software reads a counter by setting a snapshot bit. That copies the selected counter in one clock into a 64-bit holding register, which is then read as two 32-bit halves, so a counter that moves or wraps between the two reads cannot tear the result. Preload registers let software set a start value. A read-only information word reports the build parameters.

Top module: `evt_ctr_bank`

## Requirements
- R1: Register addresses: 0 control, 1 index, 2 config, 3 preload-low, 4 preload-high, 5 snapshot-low, 6 snapshot-high, 7 info. Config, preload and snapshot act on the counter named by the index. An index at or above NUM_CTR turns config and preload writes into no-ops, reads config as 0, and makes a snapshot capture 0.
- R2: A counter whose event code (config bits 14:0) is 0, or is at or above NUM_COND, never increments.
- R3: A counter adds exactly 1 on each clock edge where the run bit is set, the condition input named by its event code is high, and its qualifiers allow the current mode.
- R4: Config bit 16 allows counting in kernel mode (user_mode_i = 0) and bit 17 in user mode (user_mode_i = 1). When both are clear, the counter counts in either mode. Config reads back bits 14:0, 16 and 17 as written.
- R5: Control bit 0 is the global run bit. When it is clear, no counter changes except by preload. Control bits 31:16 store what is written and read back unchanged, and bits 15:2 read as 0.
- R6: Writing control with bit 1 set copies the value the selected counter held before that edge into the snapshot. The copy is readable from the next cycle at addresses 5 (bits 31:0) and 6 (bits 63:32). Control bit 1 always reads as 0.
- R7: A preload-low write sets counter bits 31:0, and a preload-high write sets bits W-1:32, with W = 32 + 16*SIZE_SEL. The preload replaces any increment in that cycle. Preload registers read as 0.
- R8: Counters are W bits wide and wrap from all ones to zero. Snapshot bits at and above W read as 0.
- R9: The info word has bit 31 set, bits 5:0 equal to NUM_CTR, bits 9:8 equal to SIZE_SEL, and all other bits 0. The index register reads back its 5-bit value.
- R10: After a synchronous reset, control, index, snapshot, every config and every counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cond_i | input | NUM_COND | Hardware condition inputs, one per event code |
| user_mode_i | input | 1 | Current privilege: 1 user, 0 kernel |

## Verification
The bench targets the following corner cases:
- A snapshot must capture the value from before the edge. A design that latched the post-increment value would read one too high while counting.
- A preload must override a same-cycle increment. A design that let the increment win would be one too high after a preload.
- Out-of-range event codes and out-of-range indexes must do nothing. A design that did not guard them would count on an aliased condition line or corrupt counter 0.
- The all-ones to zero wrap must leave the high snapshot word clear. A design that stored the snapshot wider than the counter would show stray upper bits.

// File: rtl/evb_pkg.sv
package evb_pkg;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_SEL  = 3'd1,
        A_CFG  = 3'd2,
        A_LDLO = 3'd3,
        A_LDHI = 3'd4,
        A_SNLO = 3'd5,
        A_SNHI = 3'd6,
        A_INFO = 3'd7
    } evb_addr_e;

    typedef struct packed {
        logic        user_ok;
        logic        kern_ok;
        logic [14:0] ev_code;
    } evb_cfg_t;

    function automatic evb_cfg_t word_to_cfg(logic [31:0] w);
        evb_cfg_t c;
        c.ev_code = w[14:0];
        c.kern_ok = w[16];
        c.user_ok = w[17];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(evb_cfg_t c);
        return {14'd0, c.user_ok, c.kern_ok, 1'b0, c.ev_code};
    endfunction

    // Qualifier gate: no bit set means any mode counts.
    function automatic logic mode_allows(evb_cfg_t c, logic user_mode);
        if (!c.kern_ok && !c.user_ok) return 1'b1;
        return (c.kern_ok && !user_mode) || (c.user_ok && user_mode);
    endfunction

endpackage

// File: rtl/evb_counter.sv
module evb_counter
    import evb_pkg::*;
#(
    parameter int CW       = 48,
    parameter int NUM_COND = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                user_mode_i,
    input  logic                cfg_we_i,
    input  evb_cfg_t            cfg_i,
    input  logic                lo_we_i,
    input  logic                hi_we_i,
    input  logic [31:0]         wdata_i,
    output evb_cfg_t            cfg_o,
    output logic [CW-1:0]       cnt_o
);
    localparam int CIW = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

    evb_cfg_t      cfg_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [63:0]   cnt_wide;
    logic          code_valid, hit;

    assign code_valid = (cfg_q.ev_code != 15'd0) && (32'(cfg_q.ev_code) < NUM_COND);
    assign hit = run_i && code_valid && cond_i[cfg_q.ev_code[CIW-1:0]]
               && mode_allows(cfg_q, user_mode_i);

    always_comb begin
        cnt_wide = 64'(cnt_q);
        if (lo_we_i)      cnt_wide[31:0]  = wdata_i;
        else if (hi_we_i) cnt_wide[63:32] = wdata_i;
        else if (hit)     cnt_wide        = 64'(cnt_q + CW'(1));
        cnt_d = cnt_wide[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            if (cfg_we_i) cfg_q <= cfg_i;
            cnt_q <= cnt_d;
        end
    end

    assign cfg_o = cfg_q;
    assign cnt_o = cnt_q;

    // R2
    never_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ev_code == 15'd0 && !lo_we_i && !hi_we_i) |=> (cnt_q == $past(cnt_q)));
    // R5
    halt_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !lo_we_i && !hi_we_i) |=> $stable(cnt_q));
    // R7
    preload_lo_chk: assert property (@(posedge clk) disable iff (rst)
        lo_we_i |=> (cnt_q[31:0] == $past(wdata_i)));
    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!lo_we_i && !hi_we_i) |=>
            (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + CW'(1))));
endmodule

// File: rtl/evb_snap.sv
module evb_snap (
    input  logic        clk,
    input  logic        rst,
    input  logic        take_i,
    input  logic [63:0] value_i,
    output logic [63:0] snap_o
);
    logic [63:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)         snap_q <= '0;
        else if (take_i) snap_q <= value_i;
    end

    assign snap_o = snap_q;

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(snap_q));
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evb_pkg::*;
#(
    parameter int NUM_CTR  = 4,
    parameter int NUM_COND = 8,
    parameter int SIZE_SEL = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                user_mode_i
);
    localparam int CW = 32 + 16 * SIZE_SEL;
    localparam int SW = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    evb_addr_e     addr;
    logic          run_q;
    logic [15:0]   ctrl_hi_q;
    logic [4:0]    sel_q;
    logic          sel_ok, take;
    logic [63:0]   snap;
    logic [CW-1:0] sel_cnt;
    evb_cfg_t      sel_cfg;
    evb_cfg_t      cfg_arr [NUM_CTR];
    logic [CW-1:0] cnt_arr [NUM_CTR];

    assign addr   = evb_addr_e'(reg_addr);
    assign sel_ok = 32'(sel_q) < NUM_CTR;
    assign take   = reg_we && addr == A_CTRL && reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            ctrl_hi_q <= '0;
            sel_q     <= '0;
        end else if (reg_we) begin
            if (addr == A_CTRL) begin
                run_q     <= reg_wdata[0];
                ctrl_hi_q <= reg_wdata[31:16];
            end
            if (addr == A_SEL) sel_q <= reg_wdata[4:0];
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic mine;
        assign mine = sel_ok && (sel_q[SW-1:0] == SW'(i)) && reg_we;
        evb_counter #(.CW(CW), .NUM_COND(NUM_COND)) ctr_i (
            .clk         (clk),
            .rst         (rst),
            .run_i       (run_q),
            .cond_i      (cond_i),
            .user_mode_i (user_mode_i),
            .cfg_we_i    (mine && addr == A_CFG),
            .cfg_i       (word_to_cfg(reg_wdata)),
            .lo_we_i     (mine && addr == A_LDLO),
            .hi_we_i     (mine && addr == A_LDHI),
            .wdata_i     (reg_wdata),
            .cfg_o       (cfg_arr[i]),
            .cnt_o       (cnt_arr[i])
        );
    end

    assign sel_cnt = sel_ok ? cnt_arr[sel_q[SW-1:0]] : '0;
    assign sel_cfg = sel_ok ? cfg_arr[sel_q[SW-1:0]] : '0;

    evb_snap snap_i (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .value_i (64'(sel_cnt)),
        .snap_o  (snap)
    );

    always_comb begin
        case (addr)
            A_CTRL:  reg_rdata = {ctrl_hi_q, 15'd0, run_q};
            A_SEL:   reg_rdata = {27'd0, sel_q};
            A_CFG:   reg_rdata = cfg_to_word(sel_cfg);
            A_SNLO:  reg_rdata = snap[31:0];
            A_SNHI:  reg_rdata = snap[63:32];
            A_INFO:  reg_rdata = {1'b1, 21'd0, 2'(SIZE_SEL), 2'd0, 6'(NUM_CTR)};
            default: reg_rdata = '0;
        endcase
    end

    // R6
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (snap == 64'($past(sel_cnt))));
    // R8
    snap_width_chk: assert property (@(posedge clk) disable iff (rst)
        (snap >> CW) == 64'd0);
    // R1
    bad_index_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !sel_ok) |=> (snap == 64'd0));
endmodule

// File: tb/evt_ctr_bank_tb_top.sv
module evt_ctr_bank_tb_top;
    localparam int PERIOD = 10;
    localparam int NC = 4;
    localparam int NE = 8;
    localparam int SS = 1;
    localparam int W  = 32 + 16 * SS;

    logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0, user_mode = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic [NE-1:0] cond = '0;

    int checks = 0, errors = 0;
    bit done = 0;
    bit rand_in = 1;

    logic [63:0] m_cnt [NC];
    logic [14:0] m_ev [NC];
    logic        m_kern [NC], m_user [NC];
    logic        m_run;
    logic [15:0] m_hi;
    logic [4:0]  m_sel;
    logic [63:0] m_snap;

    evt_ctr_bank #(.NUM_CTR(NC), .NUM_COND(NE), .SIZE_SEL(SS)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cond_i(cond), .user_mode_i(user_mode)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [63:0] wmask(logic [63:0] v);
        return v & ((64'd1 << W) - 64'd1);
    endfunction

    function automatic bit counts(int i, logic [NE-1:0] c, logic um);
        bit q;
        if (!m_run || m_ev[i] == 0 || m_ev[i] >= NE) return 0;
        q = (!m_kern[i] && !m_user[i]) || (m_kern[i] && !um) || (m_user[i] && um);
        return q && c[m_ev[i]];
    endfunction

    function automatic logic [31:0] exp_ctrl();
        return {m_hi, 15'd0, m_run};
    endfunction

    function automatic logic [31:0] exp_cfg();
        if (m_sel >= NC) return 0;
        return {14'd0, m_user[m_sel], m_kern[m_sel], 1'b0, m_ev[m_sel]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            m_cnt[i] = 0; m_ev[i] = 0; m_kern[i] = 0; m_user[i] = 0;
        end
        m_run = 0; m_hi = 0; m_sel = 0; m_snap = 0;
    endtask

    // One clock: drive at negedge, advance model to the next edge, return at negedge.
    task automatic cycle(bit we, logic [2:0] a, logic [31:0] wd);
        logic [63:0] nsnap;
        if (rand_in) begin
            cond = NE'($urandom);
            user_mode = 1'($urandom);
        end
        reg_we = we; reg_addr = a; reg_wdata = wd;
        nsnap = m_snap;
        if (we && a == 3'd0 && wd[1]) nsnap = (m_sel < NC) ? m_cnt[m_sel] : 64'd0;
        for (int i = 0; i < NC; i++) begin
            if (we && m_sel == i && a == 3'd3)
                m_cnt[i] = {m_cnt[i][63:32], wd};
            else if (we && m_sel == i && a == 3'd4)
                m_cnt[i] = wmask({wd, m_cnt[i][31:0]});
            else if (counts(i, cond, user_mode))
                m_cnt[i] = wmask(m_cnt[i] + 64'd1);
        end
        m_snap = nsnap;
        if (we && a == 3'd0) begin m_run = wd[0]; m_hi = wd[31:16]; end
        if (we && a == 3'd1) m_sel = wd[4:0];
        if (we && a == 3'd2 && m_sel < NC) begin
            m_ev[m_sel] = wd[14:0]; m_kern[m_sel] = wd[16]; m_user[m_sel] = wd[17];
        end
        @(posedge clk);
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string req);
        reg_we = 0; reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic snap_check(string req);
        cycle(1, 3'd0, {m_hi, 14'd0, 1'b1, m_run});
        rd(3'd5, m_snap[31:0], req);
        rd(3'd6, m_snap[63:32], req);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R10 reset state
        rd(3'd0, 32'd0, "R10");
        rd(3'd5, 32'd0, "R10");
        rd(3'd6, 32'd0, "R10");
        rd(3'd2, 32'd0, "R10");
        // R9 info word and index readback
        rd(3'd7, 32'h8000_0104, "R9");
        cycle(1, 3'd1, 32'd3);
        rd(3'd1, 32'd3, "R9");
        // R7 preload while stopped, read through snapshot (R6)
        cycle(1, 3'd3, 32'hDEAD_BEEF);
        cycle(1, 3'd4, 32'hFFFF_1234);
        rd(3'd3, 32'd0, "R7");
        snap_check("R7");
        rd(3'd6, 32'h0000_1234, "R8");
        // R5 control high bits kept, snapshot bit reads 0
        cycle(1, 3'd0, 32'hA5C3_0002);
        rd(3'd0, 32'hA5C3_0000, "R6");
        // R8 wrap: counter 0 at all ones, event 1 always high
        rand_in = 0; cond = '1; user_mode = 0;
        cycle(1, 3'd1, 32'd0);
        cycle(1, 3'd2, 32'd1);
        cycle(1, 3'd3, 32'hFFFF_FFFF);
        cycle(1, 3'd4, 32'h0000_FFFF);
        cycle(1, 3'd0, 32'd1);
        cycle(1, 3'd0, 32'd0);
        snap_check("R8");
        rd(3'd5, 32'd0, "R8");
        // R2 event 0 never counts while running
        cycle(1, 3'd2, 32'd0);
        cycle(1, 3'd0, 32'd1);
        for (int k = 0; k < 5; k++) cycle(0, 3'd0, 0);
        snap_check("R2");
        rd(3'd5, 32'd0, "R2");
        // R4 kernel-only qualifier in user mode does not count
        cycle(1, 3'd2, 32'h0001_0003);
        user_mode = 1;
        for (int k = 0; k < 4; k++) cycle(0, 3'd0, 0);
        snap_check("R4");
        rd(3'd5, 32'd0, "R4");
        user_mode = 0;
        for (int k = 0; k < 4; k++) cycle(0, 3'd0, 0);
        snap_check("R3");
        // R1 out-of-range index
        cycle(1, 3'd1, 32'd5);
        cycle(1, 3'd2, 32'h0002_0007);
        rd(3'd2, 32'd0, "R1");
        cycle(1, 3'd4, 32'h1111);
        snap_check("R1");
        rd(3'd5, 32'd0, "R1");
        cycle(1, 3'd1, 32'd0);
        rd(3'd2, 32'h0001_0003, "R1");
        // Random phase, R3 R4 R6 R7 against model
        rand_in = 1;
        for (int it = 0; it < 4000; it++) begin
            int op;
            op = int'($urandom % 12);
            case (op)
                0: cycle(1, 3'd1, 32'($urandom % 6));
                1: cycle(1, 3'd2, {14'd0, 2'($urandom), 1'b0, 15'($urandom % 12)});
                2: snap_check("R3");
                3: cycle(1, 3'd3, $urandom);
                4: cycle(1, 3'd4, $urandom);
                5: begin
                    cycle(1, 3'd0, {16'($urandom), 15'd0, 1'(($urandom % 4) != 0)});
                    rd(3'd0, exp_ctrl(), "R5");
                end
                6: rd(3'd2, exp_cfg(), "R4");
                default: cycle(0, 3'd0, 0);
            endcase
        end
        // R5 global stop
        cycle(1, 3'd0, 32'd0);
        snap_check("R5");
        for (int k = 0; k < 6; k++) cycle(0, 3'd0, 0);
        snap_check("R5");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule